// File: doc/BRIEF.md
# Two-Stage Accumulator Microcontroller

A small 16-bit soft processor meant for utility work inside a larger chip: generating I/O sequences, running simple control loops, or standing in for a tiny peripheral. There is no register file. One accumulator is the implicit source and destination of every operation. The first 256 words of the data memory act as directly addressable working registers. Each 16-bit instruction carries an 8-bit opcode in bits 15:8 and one 8-bit operand in bits 7:0. The operand is a register-area address, a zero-extended immediate, an I/O port number, a signed branch offset, or an offset for indirect addressing.

The pipeline has two stages. Stage one reads the instruction memory at the fetch address and decodes the word. Stage two reads the data memory, runs the ALU, and writes the accumulator, the pointer register or the data memory. A control state machine tracks what stage two holds:
- **ST_RESET**: the slot is empty after reset. It always moves to ST_RUN on the next edge.
- **ST_RUN**: the slot holds a live instruction. A taken branch or jump moves the machine to ST_BUBBLE. Otherwise it stays in ST_RUN.
- **ST_BUBBLE**: the instruction fetched behind a taken transfer has been discarded. The machine always returns to ST_RUN.

The reset input overrides all three transitions and forces ST_RESET. The instruction memory has a write port that is loaded while the core is held in reset.

Top module: `acc_mcu`

## Requirements
- R1: While `rst` is high, and for the first cycle after it falls, `io_rd` and `io_wr` are 0 and `io_wdata` (the accumulator) is 0. The first instruction executed is the one at address 0.
- R2: Register-operand ALU opcodes are 0x08 add, 0x0A subtract (acc minus operand), 0x0C and, 0x0E or and 0x10 xor. Each combines the accumulator with data word `operand`.
- R3: The immediate forms 0x09, 0x0B, 0x0D, 0x0F and 0x11 use the zero-extended operand. Opcode 0x21 loads the zero-extended operand into the accumulator.
- R4: Opcode 0x12 shifts the accumulator right by one bit, logically, and ignores the operand.
- R5: Opcode 0x20 loads data word `operand` into the accumulator. Opcode 0x30 stores the accumulator into that word.
- R6: Opcode 0x40 latches data word `operand` as a pointer. Opcodes 0x41 (load) and 0x42 (store) then use the address pointer + zero-extended operand.
- R7: Opcodes 0x60 always, 0x61 if acc==0, 0x62 if acc!=0 and 0x63 if acc[15] branch to the branch's own address plus the sign-extended operand.
- R8: After a taken branch or jump, the instruction already fetched behind it has no effect and produces no strobe.
- R9: Opcode 0x68 jumps to the address held in the accumulator and stores its own address + 1 into data word `operand`.
- R10: Opcode 0x51 asserts `io_wr` for exactly its one execute cycle, with `io_addr` equal to the operand and `io_wdata` equal to the accumulator.
- R11: Opcode 0x50 asserts `io_rd` with `io_addr` equal to the operand, and loads the same-cycle `io_rdata` into the accumulator. When no strobe is active, `io_addr` is 0.
- R12: Any opcode not listed above, including 0x00, changes no state and raises no strobe.
- R13: One instruction completes per cycle when no branch is taken. A load of a word stored by the previous instruction returns the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction memory write enable |
| prog_addr | input | IMEM_AW | Instruction memory write address |
| prog_data | input | 16 | Instruction word to write |
| io_addr | output | 8 | I/O port number, valid while a strobe is high |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | 16 | I/O write data (the accumulator) |
| io_rdata | input | 16 | I/O read data, returned in the same cycle |

## Verification
The test program mixes the ALU operations with both operand kinds, so register-operand and immediate decoding are told apart by their results. Store-then-load pairs on the same word and on different words separate correct memory timing from a stale read. Branches are run both taken and not taken on zero, non-zero and negative accumulators. This includes a backward loop that counts down to zero, which checks the sign of the offset and the exit condition. A chain of two jump-and-link calls shows that the discarded instruction after each transfer really is discarded and that the return address is the jump's own address plus one.

// File: rtl/mcu_pkg.sv
package mcu_pkg;

    localparam int WORD_W = 16;
    localparam int OPND_W = 8;

    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_RUN    = 2'd1,
        ST_BUBBLE = 2'd2
    } core_st_t;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_XOR  = 3'd4,
        ALU_SHR  = 3'd5,
        ALU_PASS = 3'd6
    } alu_op_t;

    typedef enum logic [1:0] {
        SRC_IMM  = 2'd0,
        SRC_DMEM = 2'd1,
        SRC_IO   = 2'd2
    } src_t;

    typedef enum logic [2:0] {
        BR_NONE = 3'd0,
        BR_ALW  = 3'd1,
        BR_Z    = 3'd2,
        BR_NZ   = 3'd3,
        BR_NEG  = 3'd4,
        BR_JAL  = 3'd5
    } br_t;

    typedef struct packed {
        logic              acc_we;
        alu_op_t           alu;
        src_t              src;
        logic              ind;
        logic              dm_we;
        logic              link;
        logic              ptr_we;
        logic              io_rd;
        logic              io_wr;
        br_t               br;
        logic [OPND_W-1:0] opnd;
    } dec_t;

endpackage

// File: rtl/mcu_imem.sv
module mcu_imem #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mcu_dmem.sv
module mcu_dmem #(
    parameter int AW = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // R13: a word written in one cycle reads back in the next
    p_store_visible_r13: assert property (@(posedge clk) disable iff (rst)
        we |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

endmodule

// File: rtl/mcu_decode.sv
module mcu_decode
    import mcu_pkg::*;
(
    input  logic [WORD_W-1:0] insn,
    output dec_t              dec
);
    logic [7:0] opc;
    assign opc = insn[15:8];

    always_comb begin
        dec      = '0;
        dec.opnd = insn[7:0];
        unique case (opc)
            8'h08, 8'h09: begin dec.acc_we = 1'b1; dec.alu = ALU_ADD; end
            8'h0A, 8'h0B: begin dec.acc_we = 1'b1; dec.alu = ALU_SUB; end
            8'h0C, 8'h0D: begin dec.acc_we = 1'b1; dec.alu = ALU_AND; end
            8'h0E, 8'h0F: begin dec.acc_we = 1'b1; dec.alu = ALU_OR;  end
            8'h10, 8'h11: begin dec.acc_we = 1'b1; dec.alu = ALU_XOR; end
            8'h12:        begin dec.acc_we = 1'b1; dec.alu = ALU_SHR; end
            8'h20: begin dec.acc_we = 1'b1; dec.alu = ALU_PASS; dec.src = SRC_DMEM; end
            8'h21: begin dec.acc_we = 1'b1; dec.alu = ALU_PASS; end
            8'h30: dec.dm_we = 1'b1;
            8'h40: dec.ptr_we = 1'b1;
            8'h41: begin
                dec.acc_we = 1'b1; dec.alu = ALU_PASS;
                dec.src = SRC_DMEM; dec.ind = 1'b1;
            end
            8'h42: begin dec.dm_we = 1'b1; dec.ind = 1'b1; end
            8'h50: begin
                dec.acc_we = 1'b1; dec.alu = ALU_PASS;
                dec.src = SRC_IO; dec.io_rd = 1'b1;
            end
            8'h51: dec.io_wr = 1'b1;
            8'h60: dec.br = BR_ALW;
            8'h61: dec.br = BR_Z;
            8'h62: dec.br = BR_NZ;
            8'h63: dec.br = BR_NEG;
            8'h68: begin dec.br = BR_JAL; dec.dm_we = 1'b1; dec.link = 1'b1; end
            default: dec.opnd = insn[7:0];
        endcase
        // register-operand ALU forms read the data memory, immediate forms do not
        if (opc >= 8'h08 && opc <= 8'h11 && !opc[0]) begin
            dec.src = SRC_DMEM;
        end
    end

endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
    import mcu_pkg::*;
(
    input  alu_op_t           op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SHR:  y = a >> 1;
            ALU_PASS: y = b;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/acc_mcu.sv
module acc_mcu
    import mcu_pkg::*;
#(
    parameter int IMEM_AW = 8,
    parameter int DMEM_AW = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_we,
    input  logic [IMEM_AW-1:0] prog_addr,
    input  logic [15:0]        prog_data,
    output logic [7:0]         io_addr,
    output logic               io_rd,
    output logic               io_wr,
    output logic [15:0]        io_wdata,
    input  logic [15:0]        io_rdata
);
    core_st_t           st_q, st_d;
    logic [IMEM_AW-1:0] pc_q, pc_d, s2_pc_q, br_tgt, br_off;
    logic [WORD_W-1:0]  acc_q, alu_y, alu_b, insn, dm_rdata, dm_wdata;
    logic [DMEM_AW-1:0] ptr_q, dm_addr;
    dec_t               dec_d, dec_q;
    logic               live, take, cond, dm_we;

    // ---- stage one: fetch and decode ----
    mcu_imem #(.AW(IMEM_AW), .DW(WORD_W)) u_imem (
        .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
        .raddr(pc_q), .rdata(insn)
    );

    mcu_decode u_dec (.insn(insn), .dec(dec_d));

    // ---- stage two: operand read, execute, write back ----
    assign live = (st_q == ST_RUN);

    always_comb begin
        if (dec_q.ind) begin
            dm_addr = ptr_q + DMEM_AW'(dec_q.opnd);
        end else begin
            dm_addr = DMEM_AW'(dec_q.opnd);
        end
    end

    assign dm_we    = live && dec_q.dm_we;
    assign dm_wdata = dec_q.link ? (WORD_W'(s2_pc_q) + 16'd1) : acc_q;

    mcu_dmem #(.AW(DMEM_AW), .DW(WORD_W)) u_dmem (
        .clk(clk), .rst(rst), .we(dm_we), .addr(dm_addr),
        .wdata(dm_wdata), .rdata(dm_rdata)
    );

    always_comb begin
        unique case (dec_q.src)
            SRC_DMEM: alu_b = dm_rdata;
            SRC_IO:   alu_b = io_rdata;
            default:  alu_b = WORD_W'(dec_q.opnd);
        endcase
    end

    mcu_alu u_alu (.op(dec_q.alu), .a(acc_q), .b(alu_b), .y(alu_y));

    always_comb begin
        unique case (dec_q.br)
            BR_ALW:  cond = 1'b1;
            BR_Z:    cond = (acc_q == '0);
            BR_NZ:   cond = (acc_q != '0);
            BR_NEG:  cond = acc_q[WORD_W-1];
            BR_JAL:  cond = 1'b1;
            default: cond = 1'b0;
        endcase
    end

    assign take   = live && cond;
    assign br_off = IMEM_AW'($signed(dec_q.opnd));
    assign br_tgt = (dec_q.br == BR_JAL) ? acc_q[IMEM_AW-1:0] : (s2_pc_q + br_off);
    assign pc_d   = take ? br_tgt : (pc_q + 1'b1);

    // ---- control state machine: next state ----
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RESET:  st_d = ST_RUN;
            ST_RUN:    st_d = take ? ST_BUBBLE : ST_RUN;
            ST_BUBBLE: st_d = ST_RUN;
            default:   st_d = ST_RESET;
        endcase
    end

    // ---- state register and pipeline registers ----
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_RESET;
            pc_q    <= '0;
            s2_pc_q <= '0;
            acc_q   <= '0;
            ptr_q   <= '0;
            dec_q   <= '0;
        end else begin
            st_q    <= st_d;
            pc_q    <= pc_d;
            s2_pc_q <= pc_q;
            dec_q   <= take ? dec_t'('0) : dec_d;
            if (live && dec_q.acc_we) begin
                acc_q <= alu_y;
            end
            if (live && dec_q.ptr_we) begin
                ptr_q <= dm_rdata[DMEM_AW-1:0];
            end
        end
    end

    // ---- outputs ----
    always_comb begin
        io_rd    = live && dec_q.io_rd;
        io_wr    = live && dec_q.io_wr;
        io_addr  = (io_rd || io_wr) ? dec_q.opnd : 8'h00;
        io_wdata = acc_q;
    end

    // ---- assertions ----
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_q == '0 && pc_q == '0 && !io_rd && !io_wr));

    p_ptr_latch_r6: assert property (@(posedge clk) disable iff (rst)
        (live && dec_q.ptr_we) |=> (ptr_q == $past(dm_rdata[DMEM_AW-1:0])));

    p_redirect_r8: assert property (@(posedge clk) disable iff (rst)
        take |=> (pc_q == $past(br_tgt) && !io_rd && !io_wr));

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({io_rd, io_wr}));

    p_in_capture_r11: assert property (@(posedge clk) disable iff (rst)
        io_rd |=> (acc_q == $past(io_rdata)));

    p_seq_fetch_r13: assert property (@(posedge clk) disable iff (rst)
        (live && !take) |=> (pc_q == $past(pc_q) + 1'b1));

endmodule

// File: tb/sim_acc_mcu.sv
`timescale 1ns/1ps
module sim_acc_mcu;

    localparam logic [7:0] OP_NOP = 8'h00, OP_ADD = 8'h08, OP_ADDI = 8'h09,
        OP_SUB = 8'h0A, OP_SUBI = 8'h0B, OP_AND = 8'h0C, OP_ANDI = 8'h0D,
        OP_OR = 8'h0E, OP_ORI = 8'h0F, OP_XOR = 8'h10, OP_XORI = 8'h11,
        OP_SHR = 8'h12, OP_LD = 8'h20, OP_LDI = 8'h21, OP_ST = 8'h30,
        OP_LDP = 8'h40, OP_LDX = 8'h41, OP_STX = 8'h42, OP_IN = 8'h50,
        OP_OUT = 8'h51, OP_BR = 8'h60, OP_BZ = 8'h61, OP_BNZ = 8'h62,
        OP_BN = 8'h63, OP_JAL = 8'h68;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic [7:0]  io_addr;
    logic        io_rd, io_wr;
    logic [15:0] io_wdata, io_rdata;

    always #2.5 clk = ~clk;

    assign io_rdata = {~io_addr, io_addr};

    acc_mcu u0 (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [15:0] prog [256];

    // reference model state
    logic [7:0]  m_pc, m_s2pc;
    logic [15:0] m_s2, m_acc;
    logic [8:0]  m_ptr;
    logic [15:0] m_dm [512];
    bit          m_bub, m_first;

    logic [15:0] last_out [256];
    int          cnt_out [256];

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [7:0] op, input logic [7:0] x);
        prog[a] = {op, x};
    endtask

    function automatic string tag_of(input logic [7:0] op);
        if (m_first) return "R1";
        if (m_bub) return "R8";
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: return "R2";
            OP_ADDI, OP_SUBI, OP_ANDI, OP_ORI, OP_XORI, OP_LDI: return "R3";
            OP_SHR: return "R4";
            OP_LD, OP_ST: return "R5";
            OP_LDP, OP_LDX, OP_STX: return "R6";
            OP_BR, OP_BZ, OP_BNZ, OP_BN: return "R7";
            OP_JAL: return "R9";
            OP_OUT: return "R10";
            OP_IN: return "R11";
            OP_NOP: return "R13";
            default: return "R12";
        endcase
    endfunction

    task automatic compare_cycle();
        logic [7:0] op, x;
        logic er, ew;
        string t;
        op = m_s2[15:8];
        x  = m_s2[7:0];
        t  = tag_of(op);
        er = !m_bub && op == OP_IN;
        ew = !m_bub && op == OP_OUT;
        chk(t, "io_rd", {15'd0, io_rd}, {15'd0, er});
        chk(t, "io_wr", {15'd0, io_wr}, {15'd0, ew});
        chk(t, "io_addr", {8'd0, io_addr}, (er || ew) ? {8'd0, x} : 16'd0);
        chk(t, "acc", io_wdata, m_acc);
        if (io_wr) begin
            last_out[io_addr] = io_wdata;
            cnt_out[io_addr]++;
        end
    endtask

    task automatic model_step();
        logic [7:0] op, x, tgt;
        logic [8:0] ia;
        bit take;
        op = m_s2[15:8];
        x  = m_s2[7:0];
        ia = m_ptr + {1'b0, x};
        tgt = m_s2pc + x;
        take = 0;
        if (!m_bub) begin
            case (op)
                OP_ADD:  m_acc = m_acc + m_dm[x];
                OP_ADDI: m_acc = m_acc + {8'd0, x};
                OP_SUB:  m_acc = m_acc - m_dm[x];
                OP_SUBI: m_acc = m_acc - {8'd0, x};
                OP_AND:  m_acc = m_acc & m_dm[x];
                OP_ANDI: m_acc = m_acc & {8'd0, x};
                OP_OR:   m_acc = m_acc | m_dm[x];
                OP_ORI:  m_acc = m_acc | {8'd0, x};
                OP_XOR:  m_acc = m_acc ^ m_dm[x];
                OP_XORI: m_acc = m_acc ^ {8'd0, x};
                OP_SHR:  m_acc = m_acc >> 1;
                OP_LD:   m_acc = m_dm[x];
                OP_LDI:  m_acc = {8'd0, x};
                OP_ST:   m_dm[x] = m_acc;
                OP_LDP:  m_ptr = m_dm[x][8:0];
                OP_LDX:  m_acc = m_dm[ia];
                OP_STX:  m_dm[ia] = m_acc;
                OP_IN:   m_acc = {~x, x};
                OP_BR:   take = 1;
                OP_BZ:   take = (m_acc == 0);
                OP_BNZ:  take = (m_acc != 0);
                OP_BN:   take = m_acc[15];
                OP_JAL: begin
                    take = 1;
                    tgt = m_acc[7:0];
                    m_dm[x] = {8'd0, m_s2pc} + 16'd1;
                end
                default: ;
            endcase
        end
        m_first = 0;
        if (take) begin
            m_s2 = 16'h0000;
            m_bub = 1;
            m_pc = tgt;
        end else begin
            m_s2 = prog[m_pc];
            m_s2pc = m_pc;
            m_bub = 0;
            m_pc = m_pc + 8'd1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R13 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            prog[i] = 16'h0000;
            last_out[i] = 16'h0000;
            cnt_out[i] = 0;
        end
        for (int i = 0; i < 512; i++) m_dm[i] = 16'h0000;
        put(0, OP_LDI, 8'h34);   put(1, OP_ST, 8'h10);    put(2, OP_LDI, 8'h0F);
        put(3, OP_ADD, 8'h10);   put(4, OP_OUT, 8'h01);   put(5, OP_SUBI, 8'h50);
        put(6, OP_OUT, 8'h02);   put(7, OP_ANDI, 8'hF0);  put(8, OP_ORI, 8'h0C);
        put(9, OP_XOR, 8'h10);   put(10, OP_SHR, 8'h00);  put(11, OP_ST, 8'h11);
        put(12, OP_LD, 8'h11);   put(13, OP_AND, 8'h10);  put(14, OP_OR, 8'h11);
        put(15, OP_SUB, 8'h10);  put(16, OP_XORI, 8'hFF); put(17, OP_IN, 8'h22);
        put(18, OP_OUT, 8'h03);  put(19, OP_LDI, 8'h40);  put(20, OP_ST, 8'h12);
        put(21, OP_LDI, 8'h77);  put(22, OP_LDP, 8'h12);  put(23, OP_STX, 8'h05);
        put(24, OP_LDI, 8'h00);  put(25, OP_LDX, 8'h05);  put(26, OP_OUT, 8'h04);
        put(27, OP_BZ, 8'h05);   put(28, OP_BNZ, 8'h03);  put(29, OP_LDI, 8'hEE);
        put(30, OP_OUT, 8'h0E);  put(31, OP_LDI, 8'h00);  put(32, OP_BZ, 8'h02);
        put(33, OP_OUT, 8'hEE);  put(34, OP_SUBI, 8'h01); put(35, OP_BN, 8'h02);
        put(36, OP_OUT, 8'hEE);  put(37, OP_LDI, 8'h03);  put(38, OP_ST, 8'h13);
        put(39, OP_LD, 8'h13);   put(40, OP_SUBI, 8'h01); put(41, OP_ST, 8'h13);
        put(42, OP_OUT, 8'h05);  put(43, OP_BNZ, 8'hFC);  put(44, OP_LDI, 8'd50);
        put(45, OP_JAL, 8'h14);  put(46, OP_OUT, 8'h07);  put(47, OP_BR, 8'h00);
        put(48, 8'hFF, 8'h00);   put(50, 8'hFF, 8'h12);   put(51, OP_LD, 8'h14);
        put(52, OP_OUT, 8'h06);  put(53, OP_LD, 8'h14);   put(54, OP_JAL, 8'h15);

        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            prog_we = 1'b1;
            prog_addr = 8'(i);
            prog_data = prog[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
        chk("R1", "acc in reset", io_wdata, 16'h0000);
        chk("R1", "io_rd in reset", {15'd0, io_rd}, 16'd0);
        chk("R1", "io_wr in reset", {15'd0, io_wr}, 16'd0);

        rst = 1'b0;
        m_pc = 8'd0; m_s2pc = 8'd0; m_s2 = 16'h0000; m_acc = 16'h0000;
        m_ptr = 9'd0; m_bub = 1; m_first = 1;
        for (int c = 0; c < 130; c++) begin
            compare_cycle();
            model_step();
            @(negedge clk);
        end

        chk("R2", "port1 add result", last_out[8'h01], 16'h0043);
        chk("R3", "port2 sub-immediate result", last_out[8'h02], 16'hFFF3);
        chk("R11", "port3 read-back", last_out[8'h03], 16'hDD22);
        chk("R6", "port4 indirect load", last_out[8'h04], 16'h0077);
        chk("R7", "port5 loop iterations", 16'(cnt_out[8'h05]), 16'd3);
        chk("R7", "port5 final count", last_out[8'h05], 16'h0000);
        chk("R8", "skipped port 0x0E writes", 16'(cnt_out[8'h0E]), 16'd0);
        chk("R8", "skipped port 0xEE writes", 16'(cnt_out[8'hEE]), 16'd0);
        chk("R9", "port6 link word", last_out[8'h06], 16'd46);
        chk("R9", "port7 after return", last_out[8'h07], 16'd46);
        chk("R8", "port7 write count", 16'(cnt_out[8'h07]), 16'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule